// File: doc/BRIEF.md
# Receive Ring Pointer Controller

This block owns the part of a shared packet memory that is set aside for incoming frames. It treats that region as a ring. Software sets the two inclusive boundaries and the read position through a byte-wide register port. The block turns a stream of received bytes into write strobes and write addresses that stay inside the region. When a write reaches the upper boundary, the next one goes back to the lower boundary.

The block keeps a committed write position that marks where the current frame began. A frame that ends well moves that position forward and raises the count of frames waiting. A frame that ends badly moves the write pointer back to the committed position. A frame that would run into data not yet read is also discarded the same way. Software hands frames back by pulsing a decrement input. The block also reports the free byte count, whether the lower boundary is odd, and whether the boundaries are inverted.

Top module: `rxring_ptr_ctrl`

## Requirements
- R1: After reset: lower bound 0, upper bound all ones, read pointer 0, write pointer 0, frame count 0, and all flags and pulses low.
- R2: The register selects are 0 (lower bound, low byte), 1 (lower bound, high byte), 2 (upper bound, low byte) and 3 (upper bound, high byte). A high byte supplies bits [ADDR_W-1:8], and any data bits above the pointer width are ignored.
- R3: A write to any byte of either bound loads the write pointer and the committed position with the new lower bound on the next cycle. In that cycle the block abandons the frame in progress, writes no incoming byte and ignores any frame end.
- R4: A write to select 4 only loads a shadow byte, and the read pointer does not change. A write to select 5 loads the read pointer with {data, shadow} in one step.
- R5: An accepted byte is written at the write pointer, and the pointer then advances by one. An accepted byte written at the upper bound is followed by a write at the lower bound.
- R6: The free count is (read - write - 1) modulo (upper - lower + 1). A byte is accepted only when the free count is nonzero, so the write pointer never lands on the read pointer.
- R7: A byte that arrives while the free count is zero sends the write pointer back to the frame's first address. The block then ignores bytes until the frame end, and that frame is discarded.
- R8: A frame end with the good flag set commits the frame and raises the count by one. A byte given in the same cycle is the frame's last byte. A frame end without the good flag, or for a frame already being dropped, restores the committed position and pulses the drop output on the next cycle.
- R9: The decrement strobe lowers the count by one. A commit and a decrement in the same cycle leave the count unchanged. The count holds at zero and at its maximum.
- R10: The odd flag equals bit 0 of the lower bound.
- R11: While the upper bound is below the lower bound, the error flag is set, no byte is written, and every frame end is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write byte |
| byte_valid | input | 1 | Incoming byte present |
| byte_data | input | 8 | Incoming byte |
| frame_end | input | 1 | End of current frame |
| frame_ok | input | 1 | Frame ended without error |
| pkt_dec | input | 1 | Software releases one frame |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| wr_ptr | output | ADDR_W | Hardware write pointer |
| start_ptr | output | ADDR_W | Lower bound of region |
| end_ptr | output | ADDR_W | Upper bound of region |
| rd_ptr | output | ADDR_W | Software read pointer |
| free_space | output | ADDR_W | Bytes writable before the read pointer |
| pkt_count | output | CNT_W | Frames waiting |
| odd_start | output | 1 | Lower bound is odd |
| cfg_err | output | 1 | Bounds inverted |
| frame_drop | output | 1 | Pulse: a frame was discarded |

## Verification
Two pairs of functions can meet in one cycle. In the first, a bound write arrives together with an incoming byte and a frame end. In the second, a frame commit arrives together with a software decrement. A reference model drives both collisions, in directed steps and in random traffic, and at every cycle it predicts the write strobe, the address, the pointers and the count. The bound write must win: no byte is written and the pointer reloads. The commit and the decrement must cancel, leaving the count unchanged.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      SEL_LOW_LO  = 3'd0,
      SEL_LOW_HI  = 3'd1,
      SEL_HIGH_LO = 3'd2,
      SEL_HIGH_HI = 3'd3,
      SEL_RD_LO   = 3'd4,
      SEL_RD_HI   = 3'd5
   } rxr_sel_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
   import rxr_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] start_q,
   output logic [ADDR_W-1:0] end_q,
   output logic [ADDR_W-1:0] rd_q,
   output logic              bound_wr,
   output logic [ADDR_W-1:0] start_nxt
);
   localparam int HI_W = ADDR_W - BYTE_W;

   rxr_sel_e          sel;
   logic [BYTE_W-1:0] rd_shadow;
   logic [HI_W-1:0]   hi_bits;

   assign sel     = rxr_sel_e'(reg_sel);
   assign hi_bits = reg_wdata[HI_W-1:0];

   generate
      if (HI_W < BYTE_W) begin : g_hi_spare
         logic [BYTE_W-1-HI_W:0] unused_hi;
         assign unused_hi = reg_wdata[BYTE_W-1:HI_W];
      end
   endgenerate

   always_comb begin
      bound_wr  = reg_we && (sel == SEL_LOW_LO || sel == SEL_LOW_HI ||
                             sel == SEL_HIGH_LO || sel == SEL_HIGH_HI);
      start_nxt = start_q;
      if (reg_we && sel == SEL_LOW_LO) start_nxt[BYTE_W-1:0]      = reg_wdata;
      if (reg_we && sel == SEL_LOW_HI) start_nxt[ADDR_W-1:BYTE_W] = hi_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= '0;
         end_q     <= '1;
         rd_q      <= '0;
         rd_shadow <= '0;
      end else if (reg_we) begin
         case (sel)
            SEL_LOW_LO, SEL_LOW_HI: start_q <= start_nxt;
            SEL_HIGH_LO: end_q[BYTE_W-1:0]      <= reg_wdata;
            SEL_HIGH_HI: end_q[ADDR_W-1:BYTE_W] <= hi_bits;
            SEL_RD_LO:   rd_shadow <= reg_wdata;
            SEL_RD_HI:   rd_q      <= {hi_bits, rd_shadow};
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rxr_ring_math.sv
module rxr_ring_math #(
   parameter int ADDR_W = 13
) (
   input  logic [ADDR_W-1:0] start_q,
   input  logic [ADDR_W-1:0] end_q,
   input  logic [ADDR_W-1:0] rd_q,
   input  logic [ADDR_W-1:0] wr_q,
   output logic [ADDR_W-1:0] free_space,
   output logic              free_zero,
   output logic [ADDR_W-1:0] wr_nxt,
   output logic              cfg_err
);
   localparam int SZ_W = ADDR_W + 1;
   localparam int T_W  = ADDR_W + 2;

   logic [SZ_W-1:0] span;
   logic [T_W-1:0]  raw;
   logic [T_W-1:0]  span_x;

   always_comb begin
      span   = {1'b0, end_q} - {1'b0, start_q} + SZ_W'(1);
      span_x = {1'b0, span};
      raw    = {2'b00, rd_q} + span_x - {2'b00, wr_q} - T_W'(1);
      free_space = (raw >= span_x) ? ADDR_W'(raw - span_x) : ADDR_W'(raw);
      free_zero  = (free_space == '0);
      wr_nxt     = (wr_q == end_q) ? start_q : wr_q + ADDR_W'(1);
      cfg_err    = (end_q < start_q);
   end
endmodule

// File: rtl/rxr_wr_ctrl.sv
module rxr_wr_ctrl #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bound_wr,
   input  logic [ADDR_W-1:0] start_nxt,
   input  logic              byte_valid,
   input  logic              frame_end,
   input  logic              frame_ok,
   input  logic              free_zero,
   input  logic [ADDR_W-1:0] wr_nxt,
   input  logic              cfg_err,
   output logic [ADDR_W-1:0] wr_q,
   output logic              accept,
   output logic              commit,
   output logic              frame_drop
);
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] wr_after;
   logic              dropping;
   logic              ovf;

   always_comb begin
      accept   = byte_valid && !bound_wr && !cfg_err && !dropping && !free_zero;
      ovf      = byte_valid && !bound_wr && !dropping && (cfg_err || free_zero);
      wr_after = accept ? wr_nxt : wr_q;
      commit   = !bound_wr && frame_end && frame_ok && !dropping && !ovf && !cfg_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q       <= '0;
         base_q     <= '0;
         dropping   <= 1'b0;
         frame_drop <= 1'b0;
      end else begin
         frame_drop <= !bound_wr && frame_end && !commit;
         if (bound_wr) begin
            wr_q     <= start_nxt;
            base_q   <= start_nxt;
            dropping <= 1'b0;
         end else if (frame_end) begin
            dropping <= 1'b0;
            if (commit) begin
               wr_q   <= wr_after;
               base_q <= wr_after;
            end else begin
               wr_q <= base_q;
            end
         end else if (ovf) begin
            wr_q     <= base_q;
            dropping <= 1'b1;
         end else begin
            wr_q <= wr_after;
         end
      end
   end
endmodule

// File: rtl/rxr_pkt_cnt.sv
module rxr_pkt_cnt #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic up, down;

   generate
      if (SATURATE) begin : g_sat
         assign up   = inc && !dec && (count != CNT_MAX);
         assign down = dec && !inc && (count != '0);
      end else begin : g_wrap
         assign up   = inc && !dec;
         assign down = dec && !inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (up)   count <= count + CNT_W'(1);
      else if (down) count <= count - CNT_W'(1);
   end
endmodule

// File: rtl/rxring_ptr_ctrl.sv
module rxring_ptr_ctrl
   import rxr_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter int CNT_W        = 8,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic              frame_end,
   input  logic              frame_ok,
   input  logic              pkt_dec,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic [ADDR_W-1:0] wr_ptr,
   output logic [ADDR_W-1:0] start_ptr,
   output logic [ADDR_W-1:0] end_ptr,
   output logic [ADDR_W-1:0] rd_ptr,
   output logic [ADDR_W-1:0] free_space,
   output logic [CNT_W-1:0]  pkt_count,
   output logic              odd_start,
   output logic              cfg_err,
   output logic              frame_drop
);
   generate
      if (ADDR_W < BYTE_W + 1 || ADDR_W > 2 * BYTE_W) begin : g_bad_addr
         $error("ADDR_W must lie between 9 and 16");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic              bound_wr;
   logic [ADDR_W-1:0] start_nxt;
   logic [ADDR_W-1:0] wr_nxt;
   logic              free_zero;
   logic              accept;
   logic              commit;

   rxr_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .start_q   (start_ptr),
      .end_q     (end_ptr),
      .rd_q      (rd_ptr),
      .bound_wr  (bound_wr),
      .start_nxt (start_nxt)
   );

   rxr_ring_math #(.ADDR_W(ADDR_W)) u_math (
      .start_q    (start_ptr),
      .end_q      (end_ptr),
      .rd_q       (rd_ptr),
      .wr_q       (wr_ptr),
      .free_space (free_space),
      .free_zero  (free_zero),
      .wr_nxt     (wr_nxt),
      .cfg_err    (cfg_err)
   );

   rxr_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .bound_wr   (bound_wr),
      .start_nxt  (start_nxt),
      .byte_valid (byte_valid),
      .frame_end  (frame_end),
      .frame_ok   (frame_ok),
      .free_zero  (free_zero),
      .wr_nxt     (wr_nxt),
      .cfg_err    (cfg_err),
      .wr_q       (wr_ptr),
      .accept     (accept),
      .commit     (commit),
      .frame_drop (frame_drop)
   );

   rxr_pkt_cnt #(.CNT_W(CNT_W), .SATURATE(CNT_SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (commit),
      .dec   (pkt_dec),
      .count (pkt_count)
   );

   assign mem_we    = accept;
   assign mem_addr  = wr_ptr;
   assign mem_wdata = byte_data;
   assign odd_start = start_ptr[0];
endmodule

// File: rtl/rxring_ptr_ctrl_chk.sv
module rxring_ptr_ctrl_chk #(
   parameter int ADDR_W = 13,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [2:0]        reg_sel,
   input logic              frame_end,
   input logic              mem_we,
   input logic [ADDR_W-1:0] wr_ptr,
   input logic [ADDR_W-1:0] start_ptr,
   input logic [ADDR_W-1:0] end_ptr,
   input logic [ADDR_W-1:0] rd_ptr,
   input logic [CNT_W-1:0]  pkt_count,
   input logic              cfg_err
);
   AST_BOUND_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel < 3'd4) |=> (wr_ptr == start_ptr)); // R3

   AST_RDLO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 3'd4) |=> $stable(rd_ptr)); // R4

   AST_WR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_err |-> (wr_ptr >= start_ptr && wr_ptr <= end_ptr)); // R5

   AST_NO_CATCHUP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !frame_end && !(reg_we && reg_sel == 3'd5)) |=> (wr_ptr != rd_ptr)); // R6

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pkt_count == $past(pkt_count) ||
                pkt_count == $past(pkt_count) + 1'b1 ||
                pkt_count == $past(pkt_count) - 1'b1)); // R9

   AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !mem_we); // R11
endmodule

bind rxring_ptr_ctrl rxring_ptr_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/rxring_ptr_ctrl_tb.sv
`timescale 1ns/1ps
module rxring_ptr_ctrl_tb;
   localparam int AW = 13;
   localparam int CW = 8;
   localparam int AMASK = (1 << AW) - 1;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [2:0] reg_sel = '0;
   logic [7:0] reg_wdata = '0;
   logic byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic frame_end = 1'b0;
   logic frame_ok = 1'b0;
   logic pkt_dec = 1'b0;
   logic mem_we;
   logic [AW-1:0] mem_addr, wr_ptr, start_ptr, end_ptr, rd_ptr, free_space;
   logic [7:0] mem_wdata;
   logic [CW-1:0] pkt_count;
   logic odd_start, cfg_err, frame_drop;

   int total = 0;
   int bad = 0;
   bit done = 0;

   int m_start, m_end, m_rd, m_sh, m_wr, m_base, m_cnt;
   bit m_drop, m_dropq;

   always #5 clk = ~clk;

   rxring_ptr_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u_dut (.*);

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int free_f();
      int sz, t;
      sz = (m_end - m_start + 1) & 'h3FFF;
      t  = (m_rd + sz - m_wr - 1) & 'h7FFF;
      if (t >= sz) t = t - sz;
      return t & AMASK;
   endfunction

   function automatic int nxt_f(input int w);
      return (w == m_end) ? m_start : ((w + 1) & AMASK);
   endfunction

   task automatic check_state();
      chk(start_ptr == m_start, "R2", "start_ptr", start_ptr, m_start);
      chk(end_ptr == m_end, "R2", "end_ptr", end_ptr, m_end);
      chk(rd_ptr == m_rd, "R4", "rd_ptr", rd_ptr, m_rd);
      chk(wr_ptr == m_wr, "R5", "wr_ptr", wr_ptr, m_wr);
      chk(pkt_count == m_cnt, "R9", "pkt_count", pkt_count, m_cnt);
      chk(odd_start == m_start[0], "R10", "odd_start", odd_start, m_start & 1);
      chk(cfg_err == (m_end < m_start), "R11", "cfg_err", cfg_err, m_end < m_start);
      chk(frame_drop == m_dropq, "R8", "frame_drop", frame_drop, m_dropq);
      if (m_end >= m_start) chk(free_space == free_f(), "R6", "free_space", free_space, free_f());
   endtask

   task automatic cyc(input bit we, input int sel, input int wd, input bit bv,
                      input bit fe, input bit fok, input bit dec);
      bit cfgw, err, acc, ovf, com;
      int fr, wafter, nst, nen, nrd, nsh;
      reg_we = we; reg_sel = 3'(sel); reg_wdata = 8'(wd);
      byte_valid = bv; byte_data = 8'($urandom); frame_end = fe; frame_ok = fok; pkt_dec = dec;
      #1;
      cfgw = we && sel < 4;
      err  = m_end < m_start;
      fr   = free_f();
      acc  = bv && !cfgw && !err && !m_drop && fr != 0;
      ovf  = bv && !cfgw && !m_drop && (err || fr == 0);
      chk(mem_we == acc, "R6", "mem_we", mem_we, acc);
      if (acc) begin
         chk(mem_addr == m_wr, "R5", "mem_addr", mem_addr, m_wr);
         chk(mem_wdata == byte_data, "R5", "mem_wdata", mem_wdata, byte_data);
      end
      nst = m_start; nen = m_end; nrd = m_rd; nsh = m_sh;
      if (we) begin
         case (sel)
            0: nst = (m_start & 'h1F00) | (wd & 'hFF);
            1: nst = (m_start & 'hFF) | ((wd & 'h1F) << 8);
            2: nen = (m_end & 'h1F00) | (wd & 'hFF);
            3: nen = (m_end & 'hFF) | ((wd & 'h1F) << 8);
            4: nsh = wd & 'hFF;
            5: nrd = ((wd & 'h1F) << 8) | m_sh;
            default: ;
         endcase
      end
      wafter = acc ? nxt_f(m_wr) : m_wr;
      com = 0;
      m_dropq = 0;
      if (cfgw) begin
         m_wr = nst; m_base = nst; m_drop = 0;
      end else if (fe) begin
         com = fok && !m_drop && !ovf && !err;
         if (com) begin m_base = wafter; m_wr = wafter; end
         else begin m_wr = m_base; m_dropq = 1; end
         m_drop = 0;
      end else if (ovf) begin
         m_wr = m_base; m_drop = 1;
      end else begin
         m_wr = wafter;
      end
      if (com && !dec && m_cnt < CMAX) m_cnt++;
      else if (dec && !com && m_cnt > 0) m_cnt--;
      m_start = nst; m_end = nen; m_rd = nrd; m_sh = nsh;
      @(negedge clk);
      check_state();
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic set_rd(input int v);
      cyc(1, 4, v & 'hFF, 0, 0, 0, 0);
      cyc(1, 5, (v >> 8) & 'hFF, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_start = 0; m_end = AMASK; m_rd = 0; m_sh = 0; m_wr = 0; m_base = 0;
      m_cnt = 0; m_drop = 0; m_dropq = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(wr_ptr == 0 && start_ptr == 0 && rd_ptr == 0, "R1", "ptrs", wr_ptr, 0);
      chk(end_ptr == AMASK, "R1", "end_ptr", end_ptr, AMASK);
      chk(pkt_count == 0 && !cfg_err && !frame_drop && !odd_start && !mem_we, "R1", "count/flags", pkt_count, 0);

      // R2: bounds, upper data bits ignored
      cyc(1, 0, 'h64, 0, 0, 0, 0);
      cyc(1, 1, 'hFE, 0, 0, 0, 0);
      chk(start_ptr == 'h1E64, "R2", "start hi masked", start_ptr, 'h1E64);
      cyc(1, 2, 'h83, 0, 0, 0, 0);
      cyc(1, 3, 'h1E, 0, 0, 0, 0);
      // R4: low byte alone leaves read pointer
      cyc(1, 4, 'h64, 0, 0, 0, 0);
      chk(rd_ptr == 0, "R4", "rd after low byte", rd_ptr, 0);
      cyc(1, 5, 'h1E, 0, 0, 0, 0);
      chk(rd_ptr == 'h1E64, "R4", "rd after high byte", rd_ptr, 'h1E64);

      // R8: good frame, last byte with frame end
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 1, 1, 0);
      chk(pkt_count == 1 && wr_ptr == 'h1E69, "R8", "commit", pkt_count, 1);
      // R8: bad frame rolls back
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk(wr_ptr == 'h1E69 && frame_drop, "R8", "bad frame rollback", wr_ptr, 'h1E69);
      // R9: commit with decrement in the same cycle
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 1, 1, 1);
      chk(pkt_count == 1, "R9", "commit+dec", pkt_count, 1);
      cyc(0, 0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk(pkt_count == 0, "R9", "dec at zero", pkt_count, 0);

      // R7: overflow, free = 24 at wr 0x1E6B
      chk(free_space == 24, "R6", "free before burst", free_space, 24);
      for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1, 0, 0, 0);
      chk(wr_ptr == 'h1E6B, "R7", "rollback on overrun", wr_ptr, 'h1E6B);
      cyc(0, 0, 0, 0, 1, 1, 0);
      chk(pkt_count == 0 && frame_drop, "R7", "overrun frame dropped", pkt_count, 0);

      // R3: bound write during a frame with a byte in the same cycle
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(1, 0, 'h64, 1, 1, 1, 0);
      chk(wr_ptr == 'h1E64 && pkt_count == 0, "R3", "reload", wr_ptr, 'h1E64);

      // random traffic with collisions
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom % 100;
         if (r < 5) set_rd('h1E64 + ($urandom % 32));
         else if (r < 7) cyc(1, 0, 'h64, $urandom % 2, $urandom % 2, 1, $urandom % 2);
         else cyc(0, 0, 0, ($urandom % 10) < 6, ($urandom % 12) == 0,
                  ($urandom % 5) != 0, ($urandom % 8) == 0);
      end
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 1, 0, 0);

      // R5: wrap in a 4-byte region 0x10..0x13
      cyc(1, 0, 'h10, 0, 0, 0, 0);
      cyc(1, 1, 'h00, 0, 0, 0, 0);
      cyc(1, 2, 'h13, 0, 0, 0, 0);
      cyc(1, 3, 'h00, 0, 0, 0, 0);
      set_rd('h10);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 1, 0);
      chk(free_space == 0 && wr_ptr == 'h13, "R6", "region full", free_space, 0);
      set_rd('h12);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 1, 1, 0);
      chk(wr_ptr == 'h11, "R5", "wrapped pointer", wr_ptr, 'h11);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 1, 0);
      chk(frame_drop == 1'b1, "R7", "full region drops", frame_drop, 1);

      // R10: odd lower bound
      cyc(1, 0, 'h11, 0, 0, 0, 0);
      chk(odd_start == 1'b1, "R10", "odd flag", odd_start, 1);

      // R11: inverted bounds
      cyc(1, 2, 'h05, 0, 0, 0, 0);
      chk(cfg_err == 1'b1, "R11", "error flag", cfg_err, 1);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 1, 1, 0);
      chk(frame_drop == 1'b1 && wr_ptr == 'h11, "R11", "frame refused", wr_ptr, 'h11);
      cyc(1, 2, 'h13, 0, 0, 0, 0);
      set_rd('h11);

      // R9: saturation at the maximum
      for (int i = 0; i < CMAX + 5; i++) cyc(0, 0, 0, 0, 1, 1, 0);
      chk(pkt_count == CMAX, "R9", "saturate max", pkt_count, CMAX);
      idle();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule